// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a word-addressed register controller for a bank of general-purpose pins. The pin count is a parameter that must be a multiple of 32. Software reaches the bank through a 32-bit register port. The port has a request channel and a read-response channel, and each channel uses a valid/ready handshake. The controller holds three kinds of state for each pin: a direction bit, an output latch bit and a 2-bit alternate-function code. It returns synchronised pin levels, and it drives the output value and the output enable of every pad.

Registers are grouped by function. Each function takes as many consecutive words as the pin count needs, so the stride between functions depends on the pin count. The output latch has no plain write path. It changes only through a write-one-to-set word and a write-one-to-clear word, so a write never disturbs pins it does not name. A pin with a nonzero alternate-function code gives its pad to a peripheral. That peripheral supplies the pin's output value and enable on a separate bus, and the code itself is exported so that outside logic can steer the pad.

The request channel applies back-pressure only while a read response is waiting and unconsumed. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read that is taken places its data on `rsp_rdata` and raises `rsp_valid` in the next cycle. Both then hold until `rsp_ready` is seen high. Writes produce no response.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction bit, latch bit and alternate-function code is zero. As a result `pad_oe`, `pad_out` and `af_code` are all zero and `rsp_valid` is low.
- R2: Let W = NPINS/32. For function index f from 0 to 6, the word address is f*W + pin/32, and the pin's bit in that word is pin mod 32. The alternate-function words start at address 7*W and take 2*W words. Any address of 9*W or above reads as zero, and a write to it changes nothing.
- R3: Function 0 (level) returns each pin's `pad_in` value after a two-flop synchroniser. A write to function 0 is ignored.
- R4: Function 1 (direction) can be read and written. A bit of 1 makes the pin an output, which sets its `pad_oe` when its alternate-function code is 0.
- R5: Function 2 (set) drives high the latch of each pin written with a 1. Bits written 0 leave their pins unchanged, and a read of this function returns zero.
- R6: Function 3 (clear) drives low the latch of each pin written with a 1. Bits written 0 leave their pins unchanged, and a read of this function returns zero.
- R7: Functions 4, 5 and 6 (rising enable, falling enable, edge status) read as zero, and writes to them are ignored.
- R8: In function 7 (alternate function), pin p has a 2-bit code at word 7*W + p/16, bits (p mod 16)*2 and the bit above it. The code can be read and written, is exported on `af_code[2p+1:2p]`, and changes only when a write is taken.
- R9: A pin whose code is 0 drives its latch bit on `pad_out` and its direction bit on `pad_oe`. A pin whose code is nonzero drives `alt_out[p]` and `alt_oe[p]` in their place.
- R10: A read that is taken raises `rsp_valid` in the next cycle. `rsp_valid` and `rsp_rdata` then hold steady until `rsp_ready` is high. `req_ready` is low while a response is waiting and `rsp_ready` is low.
- R11: A write takes effect on the clock edge where it is taken. The pins show the new state after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW = clog2(9*NPINS/32) | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NPINS | Raw pin levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| alt_out | input | NPINS | Peripheral output values |
| alt_oe | input | NPINS | Peripheral output enables |
| af_code | output | 2*NPINS | Alternate-function code per pin |

## Verification
The bench builds the block with NPINS = 96. With that value each function spans three words, a count that is not a power of two, so the address decode has to divide by a true stride. The bench drives every function region, the six-word alternate-function region and the unused addresses from 27 to 31, and it hits pins in the first, middle and last words as well as pin 95. The alternate-function fields sit 16 to a word, so a code for pin 40 falls in a different word from that pin's direction bit. This lets the bench catch a decode that wrongly shares one index for both.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int FN_COUNT = 8;

  typedef enum logic [3:0] {
    FN_LEVEL = 4'd0,
    FN_DIR   = 4'd1,
    FN_SET   = 4'd2,
    FN_CLR   = 4'd3,
    FN_RISE  = 4'd4,
    FN_FALL  = 4'd5,
    FN_EDGE  = 4'd6,
    FN_ALT   = 4'd7,
    FN_NONE  = 4'd8
  } fn_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int NWORDS = 2,
  parameter int AW     = 5,
  parameter int IW     = 2
) (
  input  logic [AW-1:0] addr,
  output fn_e           fn,
  output logic [IW-1:0] idx
);
  localparam int ALT_BASE = (FN_COUNT - 1) * NWORDS;
  localparam int ADDR_END = ALT_BASE + 2 * NWORDS;

  always_comb begin
    int a;
    a   = int'(addr);
    fn  = FN_NONE;
    idx = '0;
    if (a < ALT_BASE) begin
      fn  = fn_e'(4'(a / NWORDS));
      idx = IW'(a % NWORDS);
    end else if (a < ADDR_END) begin
      fn  = FN_ALT;
      idx = IW'(a - ALT_BASE);
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NPINS = 64
) (
  input  logic [NPINS-1:0]   lat,
  input  logic [NPINS-1:0]   dir,
  input  logic [2*NPINS-1:0] af,
  input  logic [NPINS-1:0]   alt_out,
  input  logic [NPINS-1:0]   alt_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic use_alt;
    assign use_alt    = |af[2*p +: 2];
    assign pad_out[p] = use_alt ? alt_out[p] : lat[p];
    assign pad_oe[p]  = use_alt ? alt_oe[p]  : dir[p];
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int NWORDS = NPINS / 32,
  parameter int AW     = $clog2(9 * NWORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  input  logic [NPINS-1:0]   alt_out,
  input  logic [NPINS-1:0]   alt_oe,
  output logic [2*NPINS-1:0] af_code
);
  localparam int NAFW = 2 * NWORDS;
  localparam int IW   = $clog2(NAFW);
  localparam int WW   = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [NWORDS-1:0][31:0] dir_q, lat_q, lvl_w;
  logic [NAFW-1:0][31:0]   af_q;
  logic [NPINS-1:0]        lvl;
  fn_e                     fn;
  logic [IW-1:0]           idx;
  logic [WW-1:0]           wi;
  logic                    take;
  logic [31:0]             rd_word;

  gpio_addr_dec #(.NWORDS(NWORDS), .AW(AW), .IW(IW)) u_dec (
    .addr (req_addr),
    .fn   (fn),
    .idx  (idx)
  );

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (lvl)
  );

  assign lvl_w     = lvl;
  assign wi        = idx[WW-1:0];
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
      af_q  <= '0;
    end else if (take && req_write) begin
      case (fn)
        FN_DIR:  dir_q[wi] <= req_wdata;
        FN_SET:  lat_q[wi] <= lat_q[wi] | req_wdata;
        FN_CLR:  lat_q[wi] <= lat_q[wi] & ~req_wdata;
        FN_ALT:  af_q[idx] <= req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (fn)
      FN_LEVEL: rd_word = lvl_w[wi];
      FN_DIR:   rd_word = dir_q[wi];
      FN_ALT:   rd_word = af_q[idx];
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign af_code = af_q;

  gpio_pin_mux #(.NPINS(NPINS)) u_mux (
    .lat     (lat_q),
    .dir     (dir_q),
    .af      (af_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NPINS = 64,
  parameter int AW    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [AW-1:0]      req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [31:0]        rsp_rdata,
  input logic [NPINS-1:0]   pad_out,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   alt_out,
  input logic [NPINS-1:0]   alt_oe,
  input logic [2*NPINS-1:0] af_code
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R10

  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R10

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid); // R10

  AST_AF_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(af_code)); // R8

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    AST_ALT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (af_code[2*p +: 2] != 2'b00) |-> (pad_out[p] == alt_out[p] && pad_oe[p] == alt_oe[p])); // R9
  end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .alt_out   (alt_out),
  .alt_oe    (alt_oe),
  .af_code   (af_code)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int NP = 96;
  localparam int NW = NP / 32;
  localparam int AW = $clog2(9 * NW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] pad_in = '0, alt_out = '0, alt_oe = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [2*NP-1:0] af_code;

  logic [NP-1:0]   m_dir = '0, m_lat = '0;
  logic [2*NP-1:0] m_af = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NPINS(NP)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .af_code(af_code)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [2*NP-1:0] act, input logic [2*NP-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int a);
    if (a < 7 * NW) begin
      case (a / NW)
        0: return pad_in[(a % NW) * 32 +: 32];
        1: return m_dir[(a % NW) * 32 +: 32];
        default: return 32'h0;
      endcase
    end else if (a < 9 * NW) return m_af[(a - 7 * NW) * 32 +: 32];
    return 32'h0;
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (a < 7 * NW) begin
      case (a / NW)
        1: m_dir[(a % NW) * 32 +: 32] = d;
        2: m_lat[(a % NW) * 32 +: 32] = m_lat[(a % NW) * 32 +: 32] | d;
        3: m_lat[(a % NW) * 32 +: 32] = m_lat[(a % NW) * 32 +: 32] & ~d;
        default: ;
      endcase
    end else if (a < 9 * NW) m_af[(a - 7 * NW) * 32 +: 32] = d;
  endtask

  task automatic check_pins(input string tag);
    logic [NP-1:0] eo, ee;
    for (int p = 0; p < NP; p++) begin
      eo[p] = (m_af[2*p +: 2] != 2'b00) ? alt_out[p] : m_lat[p];
      ee[p] = (m_af[2*p +: 2] != 2'b00) ? alt_oe[p]  : m_dir[p];
    end
    check(pad_out === eo, {tag, " pad_out"}, pad_out, eo);
    check(pad_oe === ee, {tag, " pad_oe"}, pad_oe, ee);
    check(af_code === m_af, {tag, " af_code"}, af_code, m_af);
  endtask

  task automatic bus(input bit wr, input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    model_write(a, d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input int a, input string tag);
    exp_q.push_back(exp_read(a));
    tag_q.push_back(tag);
    bus(1'b0, a, 32'h0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected response", rsp_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(pad_oe === '0 && pad_out === '0 && af_code === '0 && !rsp_valid,
          "R1 reset outputs", {pad_oe, pad_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 after reset");
    rd(4, "R1 dir word reset");
    rd(22, "R1 af word reset");

    wr(4, 32'h0000_FF00);
    check_pins("R4 dir outputs");
    rd(4, "R4 dir readback");

    wr(7, 32'h0000_0F00);
    check_pins("R5 set latch");
    rd(7, "R5 set reads zero");
    wr(7, 32'h0000_1000);
    check_pins("R5 set keeps others");
    wr(10, 32'h0000_0300);
    check_pins("R6 clear latch");
    rd(10, "R6 clear reads zero");

    @(negedge clk);
    pad_in = {32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF};
    repeat (2) @(negedge clk);
    rd(2, "R3 level word2");
    rd(0, "R3 level word0");
    wr(2, 32'hFFFF_FFFF);
    rd(2, "R3 level write ignored");

    wr(12, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    wr(18, 32'hFFFF_FFFF);
    check_pins("R7 edge writes ignored");
    rd(12, "R7 rise reads zero");
    rd(16, "R7 fall reads zero");
    rd(20, "R7 edge reads zero");

    alt_out[40] = 1'b1; alt_oe[40] = 1'b0;
    wr(23, 32'h0002_0000);
    check_pins("R8 R9 pin40 alt");
    check(af_code[81:80] === 2'd2, "R8 pin40 code position", af_code[81:80], 2);
    rd(23, "R8 af readback");
    alt_out[40] = 1'b0; alt_oe[40] = 1'b1;
    @(negedge clk);
    check_pins("R9 alt follows bus");

    wr(30, 32'hFFFF_FFFF);
    check_pins("R2 invalid write ignored");
    rd(30, "R2 invalid reads zero");
    wr(5, 32'h8000_0001);
    check_pins("R2 dir word2 pins 64 95");
    rd(5, "R2 dir word2 readback");
    wr(26, 32'hC000_0000);
    check_pins("R2 last af word pin95");

    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(3); req_wdata = 32'hFFFF_FFFF;
    check(pad_oe[31:0] === 32'h0, "R11 no change before edge", pad_oe[31:0], 0);
    @(negedge clk);
    req_valid = 1'b0;
    model_write(3, 32'hFFFF_FFFF);
    check_pins("R11 change after edge");

    rsp_ready = 1'b0;
    rd(4, "R10 backpressure data");
    held = rsp_rdata;
    check(rsp_valid && !req_ready, "R10 ready low while pending", {rsp_valid, req_ready}, 2);
    @(negedge clk);
    check(rsp_valid && rsp_rdata === held, "R10 response held", rsp_rdata, held);
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!rsp_valid && req_ready, "R10 drained", {rsp_valid, req_ready}, 1);
    check(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule